// File: doc/BRIEF.md
# Normal-Basis Field Arithmetic Processor

This block is an arithmetic datapath for the binary extension field GF(2^m), with elements held in a normal basis. It holds a register store of 512 field words. The store has two combinational read ports and one write port. Three execution units work on the words: an XOR adder, a cyclic rotator that squares, and a digit-serial Massey-Omura multiplier. An outside sequencer drives the block with one instruction word per cycle. The block has a data input for loading words and a registered data output for reading them back. Every result is written to the word named by the A address field.

In a normal basis, raising an element to the power 2^s is a cyclic rotation of its coefficient vector by s positions. One rotate instruction therefore performs any run of up to 63 squarings. The multiplier produces a fixed number of output coefficients per step. It always finishes in 9 steps, so the latency of a product does not depend on the field width. The product is defined by an m-by-m bilinear matrix supplied as a parameter. The intended field has m = 163. The parameter defaults describe a 5-bit field with a type-II optimal normal basis, and that field can be checked exhaustively.

Instruction word, 28 bits: operation [27:24], address A [23:15], address B [14:6], shift [5:0].

Top module: `nbf_proc`

## Requirements
- R1: While rst_ni is low, busy_o and data_vld_o are 0 and data_o is all zeros.
- R2: An instruction is accepted on a rising edge where instr_vld_i is 1 and busy_o is 0. Operation 4'h1 (load) writes data_i into the word at address A [23:15] on that edge.
- R3: Operation 4'h2 (store) puts the word at address A on data_o after the accepting edge, and pulses data_vld_o high for exactly that one cycle. At all other times data_o holds its value.
- R4: Operation 4'h3 (add) writes the bitwise XOR of the words at A and B into A on the accepting edge. A equal to B gives zero.
- R5: Operation 4'h4 (rotate) writes word A back into A with bit i moved to bit (i+s) mod m, where s is the shift field [5:0] in the range 0..63. This computes a^(2^s). An s of 0 or of m leaves the word unchanged.
- R6: Operation 4'h5 (multiply) writes the normal-basis product of words A and B into A. Coefficient k of the product is the XOR over all i,j with MUL_MAT[i*m+j] set of a[(i+k) mod m] AND b[(j+k) mod m].
- R7: The multiply result is written on the 9th rising edge after the accepting edge. busy_o is high for exactly the 9 cycles in between, and an instruction offered on the first cycle with busy_o low already reads the product.
- R8: An instruction presented while busy_o is high is ignored. It writes no word and causes no data_vld_o pulse.
- R9: Operation codes other than 4'h1 to 4'h5 change no word and do not touch data_o or data_vld_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_vld_i | input | 1 | Instruction present |
| instr_i | input | 28 | Instruction word: op, address A, address B, shift |
| data_i | input | DW | Word written by a load |
| data_o | output | DW | Word read by the most recent store |
| data_vld_o | output | 1 | One-cycle pulse when data_o is updated |
| busy_o | output | 1 | Multiply in progress; instructions are refused |

## Verification
A fault in the single-cycle units or in the write path corrupts the target word. This becomes visible on data_o only when that word is stored, one cycle after the store is accepted. A fault in the step counter or the operand rotation of the multiplier shows sooner, as a busy_o window of the wrong length. It can also show as wrong coefficients, which are spread across the 9 steps and appear once the product is read back. For that reason the 5-bit field is covered exhaustively against an independent model, which computes in the cyclotomic ring of order 11. Rotation is checked at shifts beyond m, where a fault in the modular reduction appears.

// File: rtl/nbf_pkg.sv
package nbf_pkg;
  localparam int OP_W    = 4;
  localparam int ADDR_W  = 9;
  localparam int SHIFT_W = 6;
  localparam int INSTR_W = OP_W + 2 * ADDR_W + SHIFT_W;

  // default: 5-bit field, type-II optimal normal basis, bit i*m+j = M[i][j]
  localparam int          DEF_W   = 5;
  localparam logic [24:0] DEF_MAT = 25'h1436122;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'h0,
    OP_LOAD  = 4'h1,
    OP_STORE = 4'h2,
    OP_ADD   = 4'h3,
    OP_ROT   = 4'h4,
    OP_MUL   = 4'h5
  } op_e;

  typedef struct packed {
    logic [OP_W-1:0]    op;
    logic [ADDR_W-1:0]  addr_a;
    logic [ADDR_W-1:0]  addr_b;
    logic [SHIFT_W-1:0] shift;
  } instr_t;
endpackage

// File: rtl/nbf_ram.sv
module nbf_ram #(
  parameter int DW    = 5,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [DW-1:0] qa_o,
  output logic [DW-1:0] qb_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  assign qa_o = mem[ra_i];
  assign qb_o = mem[rb_i];
endmodule

// File: rtl/nbf_rot.sv
module nbf_rot #(
  parameter int DW = 5,
  parameter int SW = 6
) (
  input  logic [DW-1:0] a_i,
  input  logic [SW-1:0] s_i,
  output logic [DW-1:0] y_o
);
  logic [2*DW-1:0] dbl;
  int unsigned     s_mod;

  // a^(2^s): bit i moves to (i+s) mod DW
  always_comb begin
    s_mod = 32'(s_i) % DW;
    dbl   = {a_i, a_i} << s_mod;
    y_o   = dbl[2*DW-1:DW];
  end
endmodule

// File: rtl/nbf_mul.sv
module nbf_mul #(
  parameter int             DW    = 5,
  parameter int             STEPS = 9,
  parameter logic [DW*DW-1:0] MAT = '0,
  localparam int DIG = (DW + STEPS - 1) / STEPS,
  localparam int CW  = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] prod_o
);
  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] a_q, b_q, acc_q, acc_nx;
  logic [DIG-1:0] dig;

  function automatic logic [DW-1:0] rotr(input logic [DW-1:0] v, input int n);
    logic [2*DW-1:0] d;
    d = {v, v} >> (n % DW);
    return d[DW-1:0];
  endfunction

  // digit g: coefficient k = step*DIG + g, operands already rotated by step*DIG
  for (genvar g = 0; g < DIG; g++) begin : g_dig
    logic [DW-1:0] ar, br;
    logic          bit_v;
    always_comb begin
      ar    = rotr(a_q, g);
      br    = rotr(b_q, g);
      bit_v = 1'b0;
      for (int i = 0; i < DW; i++) begin
        for (int j = 0; j < DW; j++) begin
          if (MAT[i*DW+j]) bit_v ^= ar[i] & br[j];
        end
      end
    end
    assign dig[g] = bit_v;
  end

  always_comb begin
    acc_nx = acc_q;
    for (int p = 0; p < DW; p++) begin
      if (run_q && cnt_q == CW'(p / DIG)) acc_nx[p] = dig[p % DIG];
    end
  end

  assign done_o = run_q && (cnt_q == CW'(STEPS - 1));
  assign busy_o = run_q;
  assign prod_o = acc_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      a_q   <= a_i;
      b_q   <= b_i;
      acc_q <= '0;
    end else if (run_q) begin
      acc_q <= acc_nx;
      a_q   <= rotr(a_q, DIG);
      b_q   <= rotr(b_q, DIG);
      if (done_o) run_q <= 1'b0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/nbf_proc.sv
module nbf_proc
  import nbf_pkg::*;
#(
  parameter int               DW        = DEF_W,
  parameter int               MUL_STEPS = 9,
  parameter logic [DW*DW-1:0] MUL_MAT   = DEF_MAT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_vld_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DW-1:0]      data_i,
  output logic [DW-1:0]      data_o,
  output logic               data_vld_o,
  output logic               busy_o
);
  localparam int DEPTH = 1 << ADDR_W;

  instr_t            ins;
  logic              issue, mul_busy, mul_done, wr_en;
  logic [ADDR_W-1:0] wr_addr, dst_q;
  logic [DW-1:0]     wr_data, rd_a, rd_b, rot_y, mul_prod;

  assign ins   = instr_t'(instr_i);
  assign issue = instr_vld_i && !mul_busy;

  nbf_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk_i (clk_i),
    .we_i  (wr_en),
    .wa_i  (wr_addr),
    .wd_i  (wr_data),
    .ra_i  (ins.addr_a),
    .rb_i  (ins.addr_b),
    .qa_o  (rd_a),
    .qb_o  (rd_b)
  );

  nbf_rot #(.DW(DW), .SW(SHIFT_W)) u_rot (
    .a_i (rd_a),
    .s_i (ins.shift),
    .y_o (rot_y)
  );

  nbf_mul #(.DW(DW), .STEPS(MUL_STEPS), .MAT(MUL_MAT)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (issue && ins.op == OP_MUL),
    .a_i     (rd_a),
    .b_i     (rd_b),
    .busy_o  (mul_busy),
    .done_o  (mul_done),
    .prod_o  (mul_prod)
  );

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = ins.addr_a;
    wr_data = '0;
    if (mul_done) begin
      wr_en   = 1'b1;
      wr_addr = dst_q;
      wr_data = mul_prod;
    end else if (issue) begin
      case (ins.op)
        OP_LOAD: begin wr_en = 1'b1; wr_data = data_i;      end
        OP_ADD:  begin wr_en = 1'b1; wr_data = rd_a ^ rd_b; end
        OP_ROT:  begin wr_en = 1'b1; wr_data = rot_y;       end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q      <= '0;
      data_o     <= '0;
      data_vld_o <= 1'b0;
    end else begin
      if (issue && ins.op == OP_MUL) dst_q <= ins.addr_a;
      data_vld_o <= issue && ins.op == OP_STORE;
      if (issue && ins.op == OP_STORE) data_o <= rd_a;
    end
  end

  assign busy_o = mul_busy;
endmodule

// File: rtl/nbf_proc_chk.sv
module nbf_proc_chk
  import nbf_pkg::*;
#(
  parameter int DW    = 5,
  parameter int STEPS = 9
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            instr_vld_i,
  input logic [OP_W-1:0] op_i,
  input logic            busy_o,
  input logic            data_vld_o,
  input logic [DW-1:0]   data_o,
  input logic            wr_en_i
);
  int unsigned busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt_q <= 0;
    else if (busy_o) busy_cnt_q <= busy_cnt_q + 1;
    else             busy_cnt_q <= 0;
  end

  p_store_vld_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |-> $past(instr_vld_i && !busy_o && op_i == OP_STORE));

  p_dout_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_vld_o |-> $stable(data_o));

  p_mul_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_vld_i && !busy_o && op_i == OP_MUL) |=> busy_o);

  p_busy_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_cnt_q < STEPS);

  p_busy_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_cnt_q == STEPS);

  p_fall_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(wr_en_i));

  p_busy_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !data_vld_o);
endmodule

bind nbf_proc nbf_proc_chk #(.DW(DW), .STEPS(MUL_STEPS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .instr_vld_i (instr_vld_i),
  .op_i        (instr_i[nbf_pkg::INSTR_W-1 -: nbf_pkg::OP_W]),
  .busy_o      (busy_o),
  .data_vld_o  (data_vld_o),
  .data_o      (data_o),
  .wr_en_i     (wr_en)
);

// File: tb/nbf_proc_tb.sv
`timescale 1ns/1ps
module nbf_proc_tb;
  localparam int          W    = 5;
  localparam logic [24:0] MAT  = 25'h1436122;
  localparam time         TCLK = 20ns;
  localparam int          NV   = 14;

  // {op, a, b, shift}
  localparam logic [19:0] VEC [NV] = '{
    {4'h3, 5'h13, 5'h0E, 6'd0},
    {4'h3, 5'h1F, 5'h1F, 6'd0},
    {4'h3, 5'h00, 5'h15, 6'd0},
    {4'h4, 5'h13, 5'h00, 6'd0},
    {4'h4, 5'h13, 5'h00, 6'd1},
    {4'h4, 5'h13, 5'h00, 6'd3},
    {4'h4, 5'h13, 5'h00, 6'd5},
    {4'h4, 5'h13, 5'h00, 6'd7},
    {4'h4, 5'h0B, 5'h00, 6'd63},
    {4'h4, 5'h1F, 5'h00, 6'd2},
    {4'h5, 5'h01, 5'h01, 6'd0},
    {4'h5, 5'h01, 5'h02, 6'd0},
    {4'h5, 5'h1F, 5'h1F, 6'd0},
    {4'h5, 5'h0B, 5'h16, 6'd0}
  };

  logic         clk, rst_n, instr_vld, dvld, busy;
  logic [27:0]  instr;
  logic [W-1:0] din, dout;
  int checks = 0, errors = 0;
  bit done = 0;

  nbf_proc #(.DW(W), .MUL_STEPS(9), .MUL_MAT(MAT)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .instr_vld_i (instr_vld),
    .instr_i     (instr),
    .data_i      (din),
    .data_o      (dout),
    .data_vld_o  (dvld),
    .busy_o      (busy)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  function automatic logic [W-1:0] ref_rot(input logic [W-1:0] a, input int s);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[(i + s) % W] = a[i];
    return r;
  endfunction

  // multiply in GF(2)[g]/(g^11-1); basis element k maps to g^e + g^-e
  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    int e [W];
    logic [10:0] pa, pb, pr;
    logic [W-1:0] r;
    e = '{1, 2, 4, 8, 5};
    pa = '0; pb = '0; pr = '0;
    for (int k = 0; k < W; k++) begin
      if (a[k]) begin pa[e[k]] = 1'b1; pa[11 - e[k]] = 1'b1; end
      if (b[k]) begin pb[e[k]] = 1'b1; pb[11 - e[k]] = 1'b1; end
    end
    for (int i = 0; i < 11; i++)
      for (int j = 0; j < 11; j++)
        if (pa[i] && pb[j]) pr[(i + j) % 11] ^= 1'b1;
    for (int k = 0; k < W; k++) r[k] = pr[e[k]] ^ pr[0];
    return r;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [8:0] aa, input logic [8:0] bb,
                      input logic [5:0] s, input logic [W-1:0] d);
    instr_vld = 1'b1;
    instr     = {op, aa, bb, s};
    din       = d;
    @(negedge clk);
    instr_vld = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic load(input logic [8:0] aa, input logic [W-1:0] d);
    send(4'h1, aa, 9'd0, 6'd0, d);
  endtask

  task automatic read(input logic [8:0] aa, output logic [W-1:0] v, output logic vl);
    send(4'h2, aa, 9'd0, 6'd0, '0);
    v  = dout;
    vl = dvld;
  endtask

  initial begin
    logic [W-1:0] v, exp;
    logic         vl;
    int           n;
    instr_vld = 1'b0; instr = '0; din = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", W'(busy), '0);
    chk("R1 vld", W'(dvld), '0);
    chk("R1 data", dout, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 load and read back, low and high addresses
    load(9'd7, 5'h15);
    load(9'd300, 5'h0A);
    read(9'd7, v, vl);
    chk("R2 load lo", v, 5'h15);
    chk("R3 vld pulse", W'(vl), 5'd1);
    read(9'd300, v, vl);
    chk("R2 load hi", v, 5'h0A);
    @(negedge clk);
    chk("R3 vld drop", W'(dvld), '0);
    chk("R3 hold", dout, 5'h0A);
    load(9'd7, 5'h01);
    chk("R3 hold after load", dout, 5'h0A);

    // vector table
    for (int t = 0; t < NV; t++) begin
      logic [3:0] op;
      logic [W-1:0] a, b;
      logic [5:0] s;
      {op, a, b, s} = VEC[t];
      load(9'd10, a);
      load(9'd20, b);
      send(op, 9'd10, 9'd20, s, '0);
      wait_idle();
      read(9'd10, v, vl);
      case (op)
        4'h3: chk($sformatf("R4 add %0d", t), v, a ^ b);
        4'h4: chk($sformatf("R5 rot %0d s=%0d", t, s), v, ref_rot(a, int'(s)));
        default: chk($sformatf("R6 mul %0d", t), v, ref_mul(a, b));
      endcase
    end

    // R4 same address operands
    load(9'd60, 5'h1B);
    send(4'h3, 9'd60, 9'd60, 6'd0, '0);
    read(9'd60, v, vl);
    chk("R4 self add", v, '0);

    // R5 rotation by m and by 0 keep the operand
    load(9'd61, 5'h19);
    send(4'h4, 9'd61, 9'd0, 6'd5, '0);
    send(4'h4, 9'd61, 9'd0, 6'd0, '0);
    read(9'd61, v, vl);
    chk("R5 rot m", v, 5'h19);

    // R7 busy window length and first-cycle readback
    load(9'd40, 5'h0A);
    load(9'd41, 5'h05);
    send(4'h5, 9'd40, 9'd41, 6'd0, '0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R7 busy cycles", W'(n), 5'd9);
    read(9'd40, v, vl);
    chk("R7 product at idle", v, ref_mul(5'h0A, 5'h05));

    // R8 instructions during busy are ignored
    load(9'd42, 5'h11);
    load(9'd43, 5'h03);
    send(4'h5, 9'd43, 9'd43, 6'd0, '0);
    send(4'h1, 9'd42, 9'd0, 6'd0, 5'h1F);
    send(4'h2, 9'd42, 9'd0, 6'd0, '0);
    chk("R8 no vld", W'(dvld), '0);
    chk("R8 dout kept", dout, ref_mul(5'h0A, 5'h05));
    wait_idle();
    read(9'd42, v, vl);
    chk("R8 no write", v, 5'h11);
    read(9'd43, v, vl);
    chk("R6 square", v, ref_mul(5'h03, 5'h03));

    // R9 undefined opcodes
    load(9'd50, 5'h0C);
    load(9'd51, 5'h03);
    read(9'd51, v, vl);
    foreach (VEC[i]) begin
      logic [3:0] opx;
      if (i > 3) break;
      opx = (i == 0) ? 4'h0 : (i == 1) ? 4'h6 : (i == 2) ? 4'h9 : 4'hF;
      send(opx, 9'd50, 9'd51, 6'd1, 5'h1F);
      chk($sformatf("R9 vld op %h", opx), W'(dvld), '0);
      chk($sformatf("R9 dout op %h", opx), dout, 5'h03);
    end
    read(9'd50, v, vl);
    chk("R9 word kept", v, 5'h0C);

    // R6 exhaustive products
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        load(9'd100, W'(a));
        load(9'd101, W'(b));
        send(4'h5, 9'd100, 9'd101, 6'd0, '0);
        wait_idle();
        read(9'd100, v, vl);
        exp = ref_mul(W'(a), W'(b));
        chk($sformatf("R6 mul %0d*%0d", a, b), v, exp);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog got hang exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule